// File: doc/BRIEF.md
# Circular Event Queue Append Engine

This block takes one interrupt event at a time and appends it as a 32-bit entry to a circular queue in system memory. For each event it fetches the queue descriptor through a read port. The descriptor gives the queue base address, the current write index with its generation bit, and the size settings. The block decodes the queue capacity, forms the entry, and issues a single memory write at the computed slot. After the write completes, it returns an updated position word through the descriptor update port.

The capacity comes from two settings. A chunk-select bit picks a base chunk of 128 bytes or 4096 bytes. A 4-bit size exponent shifts that chunk left, and each chunk has its own upper bound on the exponent. Every entry carries the queue's generation bit in its top position. The bit inverts each time the index wraps, so a consumer can tell entries written in this pass from entries left over from the previous pass.

A descriptor with an out-of-range size produces a size-error pulse and no memory traffic. A memory write that completes with an error produces a memory-error pulse and leaves the descriptor position unchanged.

Top module: `evq_append_engine`

## Requirements
- R1: `ev_ready` is high only while the engine is idle. After an event is accepted, `ev_ready` stays low until the descriptor update pulse or an error pulse has been issued, so at most one event is in flight.
- R2: Capacity in entries is 32 << E when `desc_chunk_sel` is 1 (128-byte chunk) and 1024 << E when it is 0 (4096-byte chunk). E is `desc_size_exp`, and each entry is 4 bytes.
- R3: E may be at most 4 with the 128-byte chunk and at most 12 with the 4096-byte chunk. Any other value gives a one-cycle `err_size` pulse, with no memory request and no descriptor update.
- R4: The write address is `desc_base + 4 * index`. The index is bits [IDX_W-1:0] of `desc_pos`.
- R5: The entry value is {generation, payload[30:0]}, where the generation bit is bit 31 of `desc_pos`. The entry is sent big-endian: `mem_req_data[7:0]` carries entry bits 31:24 and `mem_req_data[31:24]` carries entry bits 7:0.
- R6: After a write that completes without error, `desc_wr_valid` pulses for one cycle. `desc_wr_pos` then carries the index plus one, the same generation bit, and bits 30:IDX_W of `desc_pos` unchanged.
- R7: When the index plus one equals the capacity, the updated index is 0 and the updated generation bit is inverted.
- R8: A write response with `mem_rsp_err` set gives a one-cycle `err_mem` pulse and no descriptor update, so the next event goes to the same slot with the same generation bit.
- R9: After reset, `ev_ready` is 1. `desc_rd_req`, `mem_req_valid`, `desc_wr_valid`, `err_size` and `err_mem` are all 0.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Engine idle and accepting |
| ev_payload | input | 31 | Event payload bits |
| desc_rd_req | output | 1 | Descriptor fetch request, held until answered |
| desc_rd_valid | input | 1 | Descriptor fields valid |
| desc_base | input | ADDR_W | Queue base byte address |
| desc_pos | input | 32 | Position word: bit 31 generation, low IDX_W bits index |
| desc_chunk_sel | input | 1 | 1 = 128-byte chunk, 0 = 4096-byte chunk |
| desc_size_exp | input | 4 | Size exponent |
| desc_wr_valid | output | 1 | Position update pulse |
| desc_wr_pos | output | 32 | Updated position word |
| mem_req_valid | output | 1 | Memory write request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Write byte address |
| mem_req_data | output | 32 | Entry in big-endian byte order |
| mem_rsp_valid | input | 1 | Write response |
| mem_rsp_err | input | 1 | Write failed |
| err_size | output | 1 | Illegal size pulse |
| err_mem | output | 1 | Memory error pulse |

## Verification
The hardest case to reach is the wrap of a large queue. With the 4096-byte chunk and the top exponent, the queue holds over four million entries, far too many to fill event by event. The bench models the descriptor, so for every legal chunk and exponent pair it preloads the index two slots below capacity and sends three events, which carries each configuration across its wrap point. The smallest queue is also filled completely from index 0 with varied memory back-pressure, and every illegal exponent is offered under both chunk sizes.

// File: rtl/evq_pkg.sv
package evq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_WRITE,
    ST_WAIT,
    ST_UPDATE
  } evq_state_t;

  // log2 of the entry size in bytes
  localparam int ENTRY_LOG2 = 2;
  localparam int ENTRY_BYTES = 1 << ENTRY_LOG2;

endpackage

// File: rtl/evq_size_decode.sv
module evq_size_decode #(
  parameter int IDX_W      = 22,
  parameter int CL_LOG2    = 7,
  parameter int PG_LOG2    = 12,
  parameter int CL_MAX_EXP = 4,
  parameter int PG_MAX_EXP = 12
) (
  input  logic             chunk_sel,
  input  logic [3:0]       size_exp,
  output logic             legal,
  output logic [IDX_W:0]   capacity
);
  import evq_pkg::*;

  localparam logic [IDX_W:0] ONE = (IDX_W+1)'(1);

  int shift;
  logic in_range;

  always_comb begin
    in_range = chunk_sel ? (int'(size_exp) <= CL_MAX_EXP)
                         : (int'(size_exp) <= PG_MAX_EXP);
    shift    = (chunk_sel ? CL_LOG2 : PG_LOG2) + int'(size_exp) - ENTRY_LOG2;
    if (in_range && shift >= 0 && shift <= IDX_W) begin
      legal    = 1'b1;
      capacity = ONE << shift;
    end else begin
      legal    = 1'b0;
      capacity = '0;
    end
  end

endmodule

// File: rtl/evq_entry_format.sv
module evq_entry_format #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 22
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  index,
  input  logic              gen,
  input  logic [30:0]       payload,
  output logic [ADDR_W-1:0] addr,
  output logic [31:0]       data
);
  import evq_pkg::*;

  localparam int NBYTES = 4;

  logic [31:0] entry;

  assign entry = {gen, payload};
  assign addr  = base + ADDR_W'({index, {ENTRY_LOG2{1'b0}}});

  // byte lane b of the bus carries entry byte (NBYTES-1-b): big-endian
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign data[8*b +: 8] = entry[8*(NBYTES-1-b) +: 8];
  end

endmodule

// File: rtl/evq_ptr_advance.sv
module evq_ptr_advance #(
  parameter int IDX_W = 22
) (
  input  logic [IDX_W-1:0] index,
  input  logic             gen,
  input  logic [IDX_W:0]   capacity,
  output logic [IDX_W-1:0] next_index,
  output logic             next_gen
);
  logic [IDX_W:0] bumped;
  logic           wrap;

  assign bumped     = {1'b0, index} + (IDX_W+1)'(1);
  assign wrap       = (bumped >= capacity);
  assign next_index = wrap ? '0 : bumped[IDX_W-1:0];
  assign next_gen   = gen ^ wrap;

endmodule

// File: rtl/evq_append_engine.sv
module evq_append_engine #(
  parameter int ADDR_W     = 48,
  parameter int IDX_W      = 22,
  parameter int CL_LOG2    = 7,
  parameter int PG_LOG2    = 12,
  parameter int CL_MAX_EXP = 4,
  parameter int PG_MAX_EXP = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [30:0]       ev_payload,
  output logic              desc_rd_req,
  input  logic              desc_rd_valid,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [31:0]       desc_pos,
  input  logic              desc_chunk_sel,
  input  logic [3:0]        desc_size_exp,
  output logic              desc_wr_valid,
  output logic [31:0]       desc_wr_pos,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_data,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  output logic              err_size,
  output logic              err_mem
);
  import evq_pkg::*;

  // position word: bit 31 generation, low IDX_W bits index, rest carried through
  localparam int GEN_BIT = 31;

  evq_state_t        state;
  logic [30:0]       pay_q;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       pos_q;
  logic              chunk_q;
  logic [3:0]        exp_q;

  logic              size_ok;
  logic [IDX_W:0]    cap;
  logic [ADDR_W-1:0] slot_addr;
  logic [31:0]       slot_data;
  logic [IDX_W-1:0]  nxt_idx;
  logic              nxt_gen;

  evq_size_decode #(
    .IDX_W(IDX_W), .CL_LOG2(CL_LOG2), .PG_LOG2(PG_LOG2),
    .CL_MAX_EXP(CL_MAX_EXP), .PG_MAX_EXP(PG_MAX_EXP)
  ) u_size (
    .chunk_sel(chunk_q),
    .size_exp (exp_q),
    .legal    (size_ok),
    .capacity (cap)
  );

  evq_entry_format #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fmt (
    .base   (base_q),
    .index  (pos_q[IDX_W-1:0]),
    .gen    (pos_q[GEN_BIT]),
    .payload(pay_q),
    .addr   (slot_addr),
    .data   (slot_data)
  );

  evq_ptr_advance #(.IDX_W(IDX_W)) u_adv (
    .index     (pos_q[IDX_W-1:0]),
    .gen       (pos_q[GEN_BIT]),
    .capacity  (cap),
    .next_index(nxt_idx),
    .next_gen  (nxt_gen)
  );

  assign ev_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      pay_q         <= '0;
      base_q        <= '0;
      pos_q         <= '0;
      chunk_q       <= 1'b0;
      exp_q         <= '0;
      desc_rd_req   <= 1'b0;
      desc_wr_valid <= 1'b0;
      desc_wr_pos   <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_data  <= '0;
      err_size      <= 1'b0;
      err_mem       <= 1'b0;
    end else begin
      err_size      <= 1'b0;
      err_mem       <= 1'b0;
      desc_wr_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ev_valid) begin
            pay_q       <= ev_payload;
            desc_rd_req <= 1'b1;
            state       <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (desc_rd_valid) begin
            desc_rd_req <= 1'b0;
            base_q      <= desc_base;
            pos_q       <= desc_pos;
            chunk_q     <= desc_chunk_sel;
            exp_q       <= desc_size_exp;
            state       <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!size_ok) begin
            err_size <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= slot_addr;
            mem_req_data  <= slot_data;
            state         <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              err_mem <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              desc_wr_valid <= 1'b1;
              desc_wr_pos   <= {nxt_gen, pos_q[GEN_BIT-1:IDX_W], nxt_idx};
              state         <= ST_UPDATE;
            end
          end
        end
        ST_UPDATE: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evq_append_checker.sv
module evq_append_checker #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              desc_rd_req,
  input logic              desc_wr_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_data,
  input logic              err_size,
  input logic              err_mem
);

  // R1: accepting an event closes the input
  a_r1_accept_closes: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_ready |=> !ev_ready);

  // R1: no new event while any stage of the current one is active
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (desc_rd_req || mem_req_valid || desc_wr_valid) |-> !ev_ready);

  // R10: request held stable under back-pressure
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data));

  // R3: size error comes with no write and no update
  a_r3_size_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err_size |-> !mem_req_valid && !desc_wr_valid);

  // R8: memory error comes with no update
  a_r8_mem_err_no_update: assert property (@(posedge clk) disable iff (rst)
    err_mem |-> !desc_wr_valid);

  // R3 R8: at most one outcome signal at a time
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_size, err_mem, desc_wr_valid, mem_req_valid}));

endmodule

bind evq_append_engine evq_append_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ev_valid     (ev_valid),
  .ev_ready     (ev_ready),
  .desc_rd_req  (desc_rd_req),
  .desc_wr_valid(desc_wr_valid),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_req_data (mem_req_data),
  .err_size     (err_size),
  .err_mem      (err_mem)
);

// File: tb/test_evq_append_engine.sv
`timescale 1ns/1ps
module test_evq_append_engine;
  localparam int ADDR_W = 48;
  localparam int IDX_W  = 22;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ev_valid = 1'b0;
  logic              ev_ready;
  logic [30:0]       ev_payload = '0;
  logic              desc_rd_req;
  logic              desc_rd_valid = 1'b0;
  logic [ADDR_W-1:0] desc_base = '0;
  logic [31:0]       desc_pos = '0;
  logic              desc_chunk_sel = 1'b0;
  logic [3:0]        desc_size_exp = '0;
  logic              desc_wr_valid;
  logic [31:0]       desc_wr_pos;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [31:0]       mem_req_data;
  logic              mem_rsp_valid = 1'b0;
  logic              mem_rsp_err = 1'b0;
  logic              err_size;
  logic              err_mem;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // descriptor model
  logic [ADDR_W-1:0] m_base;
  int                m_idx;
  logic              m_gen;
  logic [8:0]        m_mid;
  logic              m_chunk;
  int                m_exp;

  always #2.5 clk = ~clk;

  evq_append_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_evq_append_engine (
    .clk(clk), .rst(rst),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_payload(ev_payload),
    .desc_rd_req(desc_rd_req), .desc_rd_valid(desc_rd_valid),
    .desc_base(desc_base), .desc_pos(desc_pos),
    .desc_chunk_sel(desc_chunk_sel), .desc_size_exp(desc_size_exp),
    .desc_wr_valid(desc_wr_valid), .desc_wr_pos(desc_wr_pos),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .err_size(err_size), .err_mem(err_mem)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int cap_of(input logic chunk, input int e);
    return chunk ? (32 << e) : (1024 << e);
  endfunction

  function automatic bit legal_of(input logic chunk, input int e);
    return chunk ? (e <= 4) : (e <= 12);
  endfunction

  task automatic run_event(input logic [30:0] pl, input bit merr, input int hold);
    bit legal;
    logic [31:0] entry, exp_data;
    logic [ADDR_W-1:0] exp_addr;
    int nidx;
    logic ngen;
    bit seen_req, seen_err;
    legal    = legal_of(m_chunk, m_exp);
    entry    = {m_gen, pl};
    exp_data = {entry[7:0], entry[15:8], entry[23:16], entry[31:24]};
    exp_addr = m_base + ADDR_W'(4 * m_idx);
    nidx     = m_idx + 1;
    ngen     = m_gen;
    if (legal && nidx == cap_of(m_chunk, m_exp)) begin
      nidx = 0;
      ngen = ~m_gen;
    end

    @(negedge clk);
    chk(ev_ready == 1'b1, "R1", "ready when idle", 64'(ev_ready), 64'd1);
    ev_valid   = 1'b1;
    ev_payload = pl;
    @(negedge clk);
    ev_valid = 1'b0;
    chk(ev_ready == 1'b0, "R1", "ready after accept", 64'(ev_ready), 64'd0);
    for (int k = 0; k < 10 && !desc_rd_req; k++) @(negedge clk);
    desc_rd_valid  = 1'b1;
    desc_base      = m_base;
    desc_pos       = {m_gen, m_mid, 22'(m_idx)};
    desc_chunk_sel = m_chunk;
    desc_size_exp  = 4'(m_exp);
    @(negedge clk);
    desc_rd_valid = 1'b0;
    seen_req = 0;
    seen_err = 0;
    for (int k = 0; k < 10; k++) begin
      if (mem_req_valid) begin seen_req = 1; break; end
      if (err_size) begin seen_err = 1; break; end
      @(negedge clk);
    end
    if (!legal) begin
      chk(seen_err && !seen_req, "R3", "illegal size error only",
          64'({seen_err, seen_req}), 64'b10);
      chk(ev_ready == 1'b1 && !desc_wr_valid, "R3", "idle, no update",
          64'({ev_ready, desc_wr_valid}), 64'b10);
      return;
    end
    chk(seen_req && !seen_err, "R3", "legal size writes",
        64'({seen_req, seen_err}), 64'b10);
    chk(mem_req_addr == exp_addr, "R4", "slot address", 64'(mem_req_addr), 64'(exp_addr));
    chk(mem_req_data == exp_data, "R5", "entry data", 64'(mem_req_data), 64'(exp_data));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == exp_addr && mem_req_data == exp_data,
          "R10", "held request", 64'(mem_req_data), 64'(exp_data));
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid == 1'b0, "R10", "request dropped", 64'(mem_req_valid), 64'd0);
    mem_rsp_valid = 1'b1;
    mem_rsp_err   = merr;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    if (merr) begin
      chk(err_mem && !desc_wr_valid, "R8", "error without update",
          64'({err_mem, desc_wr_valid}), 64'b10);
    end else begin
      chk(desc_wr_valid == 1'b1, "R6", "update pulse", 64'(desc_wr_valid), 64'd1);
      chk(desc_wr_pos == {ngen, m_mid, 22'(nidx)},
          (nidx == 0) ? "R7" : "R6", "updated position",
          64'(desc_wr_pos), 64'({ngen, m_mid, 22'(nidx)}));
      chk(ev_ready == 1'b0, "R1", "busy during update", 64'(ev_ready), 64'd0);
      m_idx = nidx;
      m_gen = ngen;
    end
    @(negedge clk);
    chk(ev_ready == 1'b1 && !desc_wr_valid && !err_mem, "R1", "idle after finish",
        64'(ev_ready), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ev_ready == 1'b1, "R9", "reset ready", 64'(ev_ready), 64'd1);
    chk(!desc_rd_req && !mem_req_valid && !desc_wr_valid && !err_size && !err_mem,
        "R9", "reset outputs quiet",
        64'({desc_rd_req, mem_req_valid, desc_wr_valid, err_size, err_mem}), 64'd0);

    // full pass of the smallest queue, through the wrap, with back-pressure
    m_base = 48'h0000_1234_5000; m_mid = 9'h15A; m_chunk = 1'b1; m_exp = 0;
    m_idx = 0; m_gen = 1'b0;
    for (int i = 0; i < 35; i++)
      run_event(31'(i * 32'h9E37_79B1) ^ 31'h2AAA_5555, 1'b0, i % 3);
    chk(m_idx == 3 && m_gen == 1'b1, "R7", "position after full pass",
        64'({m_gen, 22'(m_idx)}), 64'({1'b1, 22'd3}));

    // every legal size: start two below capacity and cross the wrap (R2)
    for (int c = 0; c < 2; c++) begin
      for (int e = 0; e < 16; e++) begin
        if (!legal_of(c[0], e)) continue;
        m_chunk = c[0]; m_exp = e;
        m_base  = 48'h0000_8000_0000 + 48'(e * 48'h10_0000);
        m_idx   = cap_of(c[0], e) - 2;
        m_gen   = e[0];
        m_mid   = 9'(e * 37);
        for (int i = 0; i < 3; i++)
          run_event(31'h7FFF_FFFF - 31'(i * 977 + e), 1'b0, 0);
        chk(m_idx == 1 && m_gen == ~e[0], "R2", "wrap at decoded capacity",
            64'({m_gen, 22'(m_idx)}), 64'({~e[0], 22'd1}));
      end
    end

    // every illegal exponent under both chunk sizes
    m_idx = 5; m_gen = 1'b0;
    for (int c = 0; c < 2; c++) begin
      for (int e = 0; e < 16; e++) begin
        if (legal_of(c[0], e)) continue;
        m_chunk = c[0]; m_exp = e;
        run_event(31'(e), 1'b0, 0);
      end
    end

    // memory error: position kept, retried event lands in same slot (R8)
    m_chunk = 1'b0; m_exp = 1; m_base = 48'h0000_0040_0000;
    m_idx = 2047; m_gen = 1'b1; m_mid = 9'h0F0;
    run_event(31'h1357_2468, 1'b1, 1);
    run_event(31'h1357_2468, 1'b1, 0);
    run_event(31'h0ACE_0BDF, 1'b0, 2);
    chk(m_idx == 0 && m_gen == 1'b0, "R8", "retry after error wraps once",
        64'({m_gen, 22'(m_idx)}), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule